// File: doc/BRIEF.md
# Tick Prescaler Bank with Indirect Reload Access

This block holds a parameterized set of one to eight free-running down-counting prescalers. Each one produces a single-cycle tick enable that downstream PWM channels can use as a slowed-down time base. A prescaler counts from its reload value down to zero. On the cycle its count is zero it raises its tick, and on the following edge it reloads. A reload value of R therefore gives a tick every R+1 clocks.

Software reaches the reload values through one shared data register instead of one address per prescaler. First it writes a 3-bit select field, bits 10:8, into a global control word. Then it writes or reads the data register, and that access goes to the chosen prescaler. A write to the data register leaves the control word untouched, so every other control bit survives any number of reload writes.

A read-only capability word tells software how many prescalers are built in. A new reload value never cuts a count short: it is picked up at the next natural reload.

Top module: `tick_prescaler_bank`

## Requirements
- R1: After reset every prescaler's reload value is all ones, the control word reads zero and no tick is asserted.
- R2: The capability word at offset 0xC reads the implemented prescaler count minus one in bits 15:13, with all other bits zero.
- R3: A write to the data register at offset 0x4 loads only the prescaler whose index is in control bits 10:8. The control word is at offset 0x0.
- R4: The control word stores every bit written to it. A write to the data register leaves the control word unchanged.
- R5: A data register write whose select index is at or above the prescaler count changes no reload value. A data register read with such a select returns zero.
- R6: A read of the data register returns the reload value of the selected prescaler, zero-extended.
- R7: With reload value R greater than zero, a prescaler's tick is high for exactly one clock and repeats every R+1 clocks.
- R8: With reload value zero, a prescaler's tick is high on every clock.
- R9: A reload value written in mid-count does not change the current count. It takes effect from the next reload onward.
- R10: A prescaler left at its reset reload value ticks once every 2^PSC_W clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| tick_o | output | NUM_PSC | One tick enable per prescaler |

## Verification
The hardest case to reach is a reload write that lands in the middle of a count. That write must not move the tick that is already scheduled, yet it must set every later interval. The stimulus first waits for a tick on the target prescaler. It then writes a shorter reload one cycle later, while the old count is still running, and timestamps the next two ticks. The first interval must still follow the old value and the second must follow the new one. A second hard case is the out-of-range select: after the write, every reload value is read back through the data register to show that none of them moved.

// File: rtl/psc_pkg.sv
package psc_pkg;
  // register byte offsets
  localparam int unsigned OFS_CTRL   = 32'h0;
  localparam int unsigned OFS_RELOAD = 32'h4;
  localparam int unsigned OFS_CAPS   = 32'hC;
  // select field inside the control word
  localparam int unsigned SEL_LSB    = 8;
  localparam int unsigned SEL_W      = 3;
  // prescaler count field inside the capability word
  localparam int unsigned CAP_LSB    = 13;
  localparam int unsigned CAP_W      = 3;
  localparam int unsigned MAX_PSC    = 8;
endpackage

// File: rtl/psc_rst_sync.sv
module psc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/psc_unit.sv
module psc_unit #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PSC_W-1:0] load_val,
  output logic [PSC_W-1:0] reload_q,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q, cnt_d, reload_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick    = at_zero;

  // next state: a new reload value only reaches the counter at its next wrap
  always_comb begin
    reload_d = reload_q;
    if (load_en) reload_d = load_val;
    if (at_zero) cnt_d = reload_q;
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      cnt_q    <= '1;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(reload_q)); // R3
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_q != '0) |=> !tick); // R7
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_q == '0) |=> tick); // R8
  AST_WRAP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(reload_q)); // R9
endmodule

// File: rtl/psc_regif.sv
module psc_regif
  import psc_pkg::*;
#(
  parameter int unsigned NUM_PSC = 4,
  parameter int unsigned PSC_W   = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic [NUM_PSC*PSC_W-1:0] reload_all,
  output logic [NUM_PSC-1:0]       load_vec,
  output logic [PSC_W-1:0]         load_val,
  output logic [DATA_W-1:0]        reg_rdata
);
  localparam logic [CAP_W-1:0] CAP_VAL = CAP_W'(NUM_PSC - 1);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [SEL_W-1:0]  sel;
  logic              hit_ctrl, hit_reload, hit_caps;
  logic              ctrl_wr, reload_wr, sel_valid;
  logic [PSC_W-1:0]  sel_reload;
  logic [DATA_W-1:0] caps_word;

  assign hit_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
  assign hit_reload = (reg_addr == ADDR_W'(OFS_RELOAD));
  assign hit_caps   = (reg_addr == ADDR_W'(OFS_CAPS));
  assign ctrl_wr    = reg_we && hit_ctrl;
  assign reload_wr  = reg_we && hit_reload;
  assign sel        = ctrl_q[SEL_LSB +: SEL_W];
  assign sel_valid  = (int'(sel) < int'(NUM_PSC));
  assign load_val   = reg_wdata[PSC_W-1:0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  generate
    for (genvar i = 0; i < NUM_PSC; i++) begin : g_load
      assign load_vec[i] = reload_wr && (sel == SEL_W'(i));
    end
  endgenerate

  always_comb begin
    sel_reload = '0;
    for (int i = 0; i < NUM_PSC; i++) begin
      if (sel == SEL_W'(i)) sel_reload = reload_all[i*PSC_W +: PSC_W];
    end
  end

  always_comb begin
    caps_word = '0;
    caps_word[CAP_LSB +: CAP_W] = CAP_VAL;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl)                    reg_rdata = ctrl_q;
    else if (hit_reload && sel_valid) reg_rdata = DATA_W'(sel_reload);
    else if (hit_caps)               reg_rdata = caps_word;
  end

  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q)); // R4
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec)); // R3
  AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_wr |-> load_vec == '0); // R3
endmodule

// File: rtl/tick_prescaler_bank.sv
module tick_prescaler_bank
  import psc_pkg::*;
#(
  parameter int unsigned NUM_PSC = 4,
  parameter int unsigned PSC_W   = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_PSC-1:0] tick_o
);
  logic                     rst_sync_n;
  logic [NUM_PSC-1:0]       load_vec;
  logic [PSC_W-1:0]         load_val;
  logic [NUM_PSC*PSC_W-1:0] reload_all;
  logic [SEL_W-1:0]         ctrl_sel;
  logic                     oob_write;

  psc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psc_regif #(
    .NUM_PSC (NUM_PSC),
    .PSC_W   (PSC_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reload_all (reload_all),
    .load_vec   (load_vec),
    .load_val   (load_val),
    .reg_rdata  (reg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_PSC; i++) begin : g_psc
      psc_unit #(.PSC_W(PSC_W)) u_unit (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .load_en  (load_vec[i]),
        .load_val (load_val),
        .reload_q (reload_all[i*PSC_W +: PSC_W]),
        .tick     (tick_o[i])
      );
    end
  endgenerate

  assign ctrl_sel  = u_regif.ctrl_q[SEL_LSB +: SEL_W];
  assign oob_write = reg_we && (reg_addr == ADDR_W'(OFS_RELOAD)) &&
                     (int'(ctrl_sel) >= int'(NUM_PSC));

  AST_OOB_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    oob_write |=> $stable(reload_all)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> tick_o == '0); // R1
endmodule

// File: tb/tick_prescaler_bank_tb.sv
module tick_prescaler_bank_tb;
  localparam int NUM = 4;
  localparam int PW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [3:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NUM-1:0]  tick_o;
  int              n_run = 0;
  int              n_fail = 0;
  int              cyc = 0;
  bit              finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  tick_prescaler_bank #(.NUM_PSC(NUM), .PSC_W(PW), .ADDR_W(4), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_o(tick_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic select(input int idx);
    wr(4'h0, 32'(idx) << 8);
  endtask

  task automatic wait_tick(input int i, output int t);
    do @(negedge clk); while (!tick_o[i]);
    t = cyc;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 tick idle", 32'(tick_o), 32'h0);
    rd(4'h0, d); check("R1 ctrl", d, 32'h0);
    for (int i = 0; i < NUM; i++) begin
      select(i); rd(4'h4, d); check("R1 reload all ones", d, 32'hFF);
    end
    select(0);
  endtask

  task automatic t_caps;
    logic [31:0] d;
    rd(4'hC, d); check("R2 caps", d, 32'(NUM - 1) << 13);
  endtask

  task automatic t_reset_period;
    int t1, t2;
    wait_tick(3, t1); wait_tick(3, t2);
    check("R10 reset period", 32'(t2 - t1), 32'd256);
  endtask

  task automatic t_select_load;
    logic [31:0] d;
    select(1); wr(4'h4, 32'h14);
    select(0); wr(4'h4, 32'h09);
    select(2); wr(4'h4, 32'h00);
    select(1); rd(4'h4, d); check("R6 read sel1", d, 32'h14);
    select(0); rd(4'h4, d); check("R3 load sel0", d, 32'h09);
    select(2); rd(4'h4, d); check("R3 load sel2", d, 32'h00);
    select(3); rd(4'h4, d); check("R3 others untouched", d, 32'hFF);
  endtask

  task automatic t_ctrl_keep;
    logic [31:0] d;
    wr(4'h0, 32'hA5C3_F2E1);
    rd(4'h0, d); check("R4 ctrl stores", d, 32'hA5C3_F2E1);
    wr(4'h4, 32'h33);
    rd(4'h0, d); check("R4 ctrl kept", d, 32'hA5C3_F2E1);
    // select field is 2 -> reload of prescaler 2 was written
    rd(4'h4, d); check("R3 sel from mixed ctrl", d, 32'h33);
    select(2); wr(4'h4, 32'h00);
  endtask

  task automatic t_oob;
    logic [31:0] d;
    select(5); wr(4'h4, 32'h77);
    rd(4'h4, d); check("R5 oob read zero", d, 32'h0);
    select(0); rd(4'h4, d); check("R5 oob p0", d, 32'h09);
    select(1); rd(4'h4, d); check("R5 oob p1", d, 32'h14);
    select(2); rd(4'h4, d); check("R5 oob p2", d, 32'h00);
    select(3); rd(4'h4, d); check("R5 oob p3", d, 32'hFF);
  endtask

  task automatic t_period;
    int t0, t1, t2;
    wait_tick(0, t0); wait_tick(0, t1);
    @(negedge clk); check("R7 single cycle", 32'(tick_o[0]), 32'h0);
    wait_tick(0, t2);
    check("R7 period", 32'(t2 - t1), 32'd10);
  endtask

  task automatic t_zero;
    int t0;
    wait_tick(2, t0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R8 every cycle", 32'(tick_o[2]), 32'h1);
    end
  endtask

  task automatic t_midcount;
    int t0, t1, t2, t3;
    wait_tick(1, t0); wait_tick(1, t1);
    check("R7 period 21", 32'(t1 - t0), 32'd21);
    select(1); wr(4'h4, 32'h05);
    wait_tick(1, t2); wait_tick(1, t3);
    check("R9 old count kept", 32'(t2 - t1), 32'd21);
    check("R9 new at reload", 32'(t3 - t2), 32'd6);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_caps();
    t_reset_period();
    t_select_load();
    t_ctrl_keep();
    t_oob();
    t_period();
    t_zero();
    t_midcount();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule